// File: doc/BRIEF.md
# SPI Flash Hardware Sequencer

This block lets a host run single operations on a serial flash device without handling the serial protocol itself. The host programs a flash address, places write data in a local byte buffer when needed, then writes the control/status word. That word selects the cycle type and the byte count and carries the start bit. The engine drives a mode-0 SPI master port. It sends the opcode, the address and the data bytes, captures any returned bytes into the buffer, and then raises a sticky completion flag. An argument the engine cannot execute raises a sticky error flag instead, and no chip select is asserted.

An index/data register pair gives access to the flash's parameter table. Writing the index register starts a fixed parameter-read transaction. When it finishes, the returned 32-bit word can be read from the data register.

The register bus is a single-cycle write strobe with byte enables and a combinational read port. Word registers ignore address bits [1:0]. The buffer occupies the upper half of the register space, and its byte enables give byte-granular writes. Register words: 0x00 flash address [23:0]; 0x04 control/status; 0x08 parameter index; 0x0C parameter data (read only); 0x40 to 0x7F data buffer, with byte n in lane n mod 4.

Top module: `spi_flash_hwseq`

## Requirements
- R1: After reset, the control/status word, the address word, the parameter index and the parameter data all read 0. The chip select output is high and the serial clock is low.
- R2: Control/status word layout: bit 0 is done, bit 1 is error, bit 2 is busy, bit 3 is go (write only, reads 0), bits [6:4] are the cycle code and bits [21:16] are the byte count minus one. Cycle codes are 0 read, 1 program, 2 4 KiB erase, 3 64 KiB erase and 4 read status.
- R3: A read cycle sends opcode 0x03 and then the 24-bit address, most significant byte first. It then clocks in count+1 bytes and stores them in buffer bytes 0 to count.
- R4: A program cycle sends opcode 0x02, the 24-bit address and then buffer bytes 0 to count, in that order.
- R5: Erase cycles send opcode 0x20 (4 KiB) or 0xD8 (64 KiB) with the 24-bit address and carry no data bytes.
- R6: A read-status cycle sends opcode 0x05 and places the one returned byte in buffer byte 0.
- R7: Busy reads 1 from the accepted go until the final byte ends. On the edge where busy clears, done sets.
- R8: Writing 1 to done or to error clears that bit, and writing 0 leaves it unchanged. A go write that also carries ones in bits [1:0] clears stale status.
- R9: A go with an invalid cycle code (5 to 7), or a misaligned erase address, sets error without asserting chip select, and done stays 0. A read or program whose last byte would pass address bit 8 (addr[7:0] + count > 255) is handled the same way.
- R10: A go or a parameter-index write issued while busy is ignored. The cycle field, the parameter index and the bus pins are unaffected.
- R11: Writing the parameter index stores bits [11:2] as a word index and bits [13:12] as a table select, and reads back with bits [1:0] zero. It then sends opcode 0x5A with address {10'b0, select, index, 2'b00} and one dummy byte. The four returned bytes form the parameter data word, with the first byte in bits [7:0]. Done sets when the fetch ends.
- R12: Buffer writes honour each byte enable separately. Address bits [1:0] are ignored for every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 7 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_be_i | input | 4 | Byte enables for buffer writes |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| spi_sck_o | output | 1 | Serial clock, idle low |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The hardest state to reach is a go or an index write arriving while a transaction is still shifting. The bench starts a full 64-byte read and issues a conflicting program go and a parameter-index write a few cycles later. It then checks that exactly one chip-select window occurred, that the read opcode was the one sent, and that the cycle field and index read back unchanged. The page-boundary limit is approached from both sides. A sweep of every byte count places each read so that it ends exactly on the last byte of a page. Separate cases then move the end one byte past the page, and must report an error with no chip select.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;
  localparam logic [2:0] CYC_READ  = 3'd0;
  localparam logic [2:0] CYC_PROG  = 3'd1;
  localparam logic [2:0] CYC_ER4K  = 3'd2;
  localparam logic [2:0] CYC_ER64K = 3'd3;
  localparam logic [2:0] CYC_RDSR  = 3'd4;

  localparam logic [7:0] SPI_PARAM_OP = 8'h5A;

  function automatic logic [7:0] spi_opcode(logic [2:0] cyc, logic par);
    if (par) return SPI_PARAM_OP;
    case (cyc)
      CYC_READ:  return 8'h03;
      CYC_PROG:  return 8'h02;
      CYC_ER4K:  return 8'h20;
      CYC_ER64K: return 8'hD8;
      default:   return 8'h05;
    endcase
  endfunction
endpackage

// File: rtl/hwseq_shifter.sv
module hwseq_shifter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  logic [7:0] sh_q;
  logic [2:0] bit_q;
  logic       act_q, sck_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; bit_q <= '0; act_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q <= tx_i; bit_q <= '0; act_q <= 1'b1; sck_q <= 1'b0;
      end else if (act_q) begin
        if (!sck_q) sck_q <= 1'b1;
        else begin
          // falling edge: capture bit driven at the previous falling edge
          sck_q <= 1'b0;
          sh_q  <= {sh_q[6:0], miso_i};
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            act_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign rx_o   = sh_q;
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign mosi_o = act_q & sh_q[7];
endmodule

// File: rtl/hwseq_buf.sv
module hwseq_buf #(
  parameter int BUF_BYTES = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         h_we_i,
  input  logic [$clog2(BUF_BYTES)-3:0] h_word_i,
  input  logic [3:0]                   h_be_i,
  input  logic [31:0]                  h_wd_i,
  output logic [31:0]                  h_rd_o,
  input  logic                         e_we_i,
  input  logic [$clog2(BUF_BYTES)-1:0] e_idx_i,
  input  logic [7:0]                   e_wd_i,
  output logic [7:0]                   e_rd_o
);
  localparam int AW = $clog2(BUF_BYTES);

  logic [7:0] mem_q [BUF_BYTES];

  for (genvar i = 0; i < BUF_BYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (e_we_i && e_idx_i == AW'(i)) mem_q[i] <= e_wd_i;
      else if (h_we_i && h_word_i == (AW-2)'(i / 4) && h_be_i[i % 4])
        mem_q[i] <= h_wd_i[8*(i%4) +: 8];
    end
  end

  always_comb begin
    for (int b = 0; b < 4; b++) h_rd_o[8*b +: 8] = mem_q[{h_word_i, 2'(b)}];
  end

  assign e_rd_o = mem_q[e_idx_i];
endmodule

// File: rtl/hwseq_engine.sv
module hwseq_engine import hwseq_pkg::*; #(
  parameter int BUF_BYTES = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         go_i,
  input  logic                         param_i,
  input  logic [2:0]                   cyc_i,
  input  logic [23:0]                  addr_i,
  input  logic [$clog2(BUF_BYTES)-1:0] cnt_i,
  input  logic [7:0]                   buf_rd_i,
  output logic [$clog2(BUF_BYTES)-1:0] buf_idx_o,
  output logic                         buf_we_o,
  output logic [7:0]                   rx_o,
  output logic                         pw_we_o,
  output logic [1:0]                   pw_idx_o,
  output logic                         busy_o,
  output logic                         fin_o,
  output logic                         spi_sck_o,
  output logic                         spi_cs_no,
  output logic                         spi_mosi_o,
  input  logic                         spi_miso_i
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int PW = $clog2(BUF_BYTES + 5);

  logic          busy_q, kick_q, par_q;
  logic [2:0]    cyc_q;
  logic [23:0]   a_q;
  logic [AW-1:0] c_q;
  logic [PW-1:0] pos_q, hdr, dlen, last, dpos;
  logic [7:0]    tx;
  logic          byte_done, in_data;

  always_comb begin
    hdr = par_q ? PW'(5) : (cyc_q == CYC_RDSR) ? PW'(1) : PW'(4);
    if (par_q)                                        dlen = PW'(4);
    else if (cyc_q == CYC_RDSR)                       dlen = PW'(1);
    else if (cyc_q == CYC_ER4K || cyc_q == CYC_ER64K) dlen = '0;
    else                                              dlen = PW'(c_q) + PW'(1);
    last    = hdr + dlen - PW'(1);
    dpos    = pos_q - hdr;
    in_data = pos_q >= hdr;
  end

  always_comb begin
    if (pos_q == '0)   tx = spi_opcode(cyc_q, par_q);
    else if (!in_data) begin
      case (pos_q[2:0])
        3'd1:    tx = a_q[23:16];
        3'd2:    tx = a_q[15:8];
        3'd3:    tx = a_q[7:0];
        default: tx = 8'h00;   // dummy byte
      endcase
    end else if (!par_q && cyc_q == CYC_PROG) tx = buf_rd_i;
    else tx = 8'h00;
  end

  hwseq_shifter u_shift (
    .clk_i, .rst_ni, .start_i(kick_q), .tx_i(tx), .rx_o, .done_o(byte_done),
    .sck_o(spi_sck_o), .mosi_o(spi_mosi_o), .miso_i(spi_miso_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; kick_q <= 1'b0; par_q <= 1'b0;
      cyc_q <= '0; a_q <= '0; c_q <= '0; pos_q <= '0;
    end else begin
      kick_q <= 1'b0;
      if (go_i && !busy_q) begin
        busy_q <= 1'b1; kick_q <= 1'b1; pos_q <= '0;
        par_q <= param_i; cyc_q <= cyc_i; a_q <= addr_i; c_q <= cnt_i;
      end else if (busy_q && byte_done) begin
        if (pos_q == last) busy_q <= 1'b0;
        else begin
          pos_q  <= pos_q + PW'(1);
          kick_q <= 1'b1;
        end
      end
    end
  end

  assign buf_idx_o = dpos[AW-1:0];
  assign buf_we_o  = busy_q && byte_done && in_data && !par_q &&
                     (cyc_q == CYC_READ || cyc_q == CYC_RDSR);
  assign pw_we_o   = busy_q && byte_done && in_data && par_q;
  assign pw_idx_o  = dpos[1:0];
  assign fin_o     = busy_q && byte_done && pos_q == last;
  assign busy_o    = busy_q;
  assign spi_cs_no = !busy_q;
endmodule

// File: rtl/spi_flash_hwseq.sv
module spi_flash_hwseq import hwseq_pkg::*; #(
  parameter int BUF_BYTES = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_wr_i,
  input  logic [$clog2(BUF_BYTES):0]   reg_addr_i,
  input  logic [31:0]                  reg_wdata_i,
  input  logic [3:0]                   reg_be_i,
  output logic [31:0]                  reg_rdata_o,
  output logic                         spi_sck_o,
  output logic                         spi_cs_no,
  output logic                         spi_mosi_o,
  input  logic                         spi_miso_i
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int WW = AW - 2;

  logic          is_buf;
  logic [WW-1:0] word;
  logic          ctrl_wr, go_wr, go_req, pidx_req, bad, launch, fail;
  logic [2:0]    new_cyc;
  logic [AW-1:0] new_cnt;
  logic [23:0]   addr_q, eng_addr;
  logic [2:0]    op_q;
  logic [AW-1:0] cnt_q;
  logic          done_q, err_q;
  logic [11:0]   pidx_q;
  logic [31:0]   pdata_q, buf_word, ctrl_rd;
  logic          eng_busy, fin, buf_we, pw_we;
  logic [AW-1:0] buf_idx;
  logic [7:0]    rx, buf_rd;
  logic [1:0]    pw_idx;
  logic          unused_lo;

  assign unused_lo = ^reg_addr_i[1:0];
  assign is_buf    = reg_addr_i[AW];
  assign word      = reg_addr_i[AW-1:2];
  assign ctrl_wr   = reg_wr_i && !is_buf && word == WW'(1);
  assign go_wr     = ctrl_wr && reg_wdata_i[3];
  assign go_req    = go_wr && !eng_busy;
  assign pidx_req  = reg_wr_i && !is_buf && word == WW'(2) && !eng_busy;
  assign new_cyc   = reg_wdata_i[6:4];
  assign new_cnt   = reg_wdata_i[16 +: AW];

  always_comb begin
    case (new_cyc)
      CYC_READ, CYC_PROG: bad = ({1'b0, addr_q[7:0]} + 9'(new_cnt)) > 9'd255;
      CYC_ER4K:           bad = addr_q[11:0] != '0;
      CYC_ER64K:          bad = addr_q[15:0] != '0;
      CYC_RDSR:           bad = 1'b0;
      default:            bad = 1'b1;
    endcase
  end
  assign launch   = go_req && !bad;
  assign fail     = go_req && bad;
  assign eng_addr = pidx_req ? {10'b0, reg_wdata_i[13:2], 2'b00} : addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0; op_q <= '0; cnt_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
      pidx_q <= '0; pdata_q <= '0;
    end else begin
      if (reg_wr_i && !is_buf && word == WW'(0)) addr_q <= reg_wdata_i[23:0];
      if (go_req) begin
        op_q  <= new_cyc;
        cnt_q <= new_cnt;
      end
      if (pidx_req) pidx_q <= reg_wdata_i[13:2];
      if (pw_we) pdata_q[8*pw_idx +: 8] <= rx;
      // set wins over a same-cycle write-one-to-clear
      done_q <= (done_q && !(ctrl_wr && reg_wdata_i[0])) || fin;
      err_q  <= (err_q  && !(ctrl_wr && reg_wdata_i[1])) || fail;
    end
  end

  hwseq_engine #(.BUF_BYTES(BUF_BYTES)) u_eng (
    .clk_i, .rst_ni, .go_i(launch || pidx_req), .param_i(pidx_req),
    .cyc_i(new_cyc), .addr_i(eng_addr), .cnt_i(new_cnt),
    .buf_rd_i(buf_rd), .buf_idx_o(buf_idx), .buf_we_o(buf_we), .rx_o(rx),
    .pw_we_o(pw_we), .pw_idx_o(pw_idx), .busy_o(eng_busy), .fin_o(fin),
    .spi_sck_o, .spi_cs_no, .spi_mosi_o, .spi_miso_i
  );

  hwseq_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk_i, .rst_ni, .h_we_i(reg_wr_i && is_buf), .h_word_i(word),
    .h_be_i(reg_be_i), .h_wd_i(reg_wdata_i), .h_rd_o(buf_word),
    .e_we_i(buf_we), .e_idx_i(buf_idx), .e_wd_i(rx), .e_rd_o(buf_rd)
  );

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[0]       = done_q;
    ctrl_rd[1]       = err_q;
    ctrl_rd[2]       = eng_busy;
    ctrl_rd[6:4]     = op_q;
    ctrl_rd[16 +: AW] = cnt_q;
    if (is_buf) reg_rdata_o = buf_word;
    else begin
      case (word)
        WW'(0):  reg_rdata_o = {8'b0, addr_q};
        WW'(1):  reg_rdata_o = ctrl_rd;
        WW'(2):  reg_rdata_o = {18'b0, pidx_q, 2'b00};
        WW'(3):  reg_rdata_o = pdata_q;
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_hwseq_chk.sv
module spi_flash_hwseq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       done_i,
  input logic       err_i,
  input logic       go_wr_i,
  input logic [2:0] op_i,
  input logic       cs_ni,
  input logic       sck_i
);
  AST_SCK_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_i |-> !cs_ni);  // R7
  AST_DONE_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(busy_i));  // R7
  AST_BUSY_END_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> done_i);  // R7
  AST_ERR_NO_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> cs_ni && $past(cs_ni));  // R9
  AST_ERR_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> !$rose(done_i));  // R9
  AST_GO_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && go_wr_i) |=> $stable(op_i));  // R10
endmodule

bind spi_flash_hwseq spi_flash_hwseq_chk u_chk (
  .clk_i, .rst_ni, .busy_i(eng_busy), .done_i(done_q), .err_i(err_q),
  .go_wr_i(go_wr), .op_i(op_q), .cs_ni(spi_cs_no), .sck_i(spi_sck_o)
);

// File: tb/spi_flash_hwseq_tb.sv
module spi_flash_hwseq_tb;
  localparam logic [6:0] A_ADDR = 7'h00, A_CTRL = 7'h04, A_PIDX = 7'h08,
                         A_PDATA = 7'h0C, A_BUF = 7'h40;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  reg_be = '0;
  logic        sck, cs_n, mosi, miso = 1'b0;
  int          n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_flash_hwseq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_be_i(reg_be), .reg_rdata_o(reg_rdata),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  // flash model
  logic [7:0] rxb [0:127];
  logic [7:0] sh = '0;
  int         bitn = 0, cs_falls = 0;

  function automatic logic [7:0] fpat(logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic mbit(int n);
    logic [7:0] opc, b;
    logic [23:0] a;
    int hdr, k;
    opc = rxb[0];
    a = {rxb[1], rxb[2], rxb[3]};
    hdr = (opc == 8'h05) ? 1 : (opc == 8'h5A) ? 5 : 4;
    k = n / 8 - hdr;
    if (k < 0) return 1'b0;
    b = (opc == 8'h05) ? 8'h9C : fpat(a + 24'(k));
    return b[7 - (n % 8)];
  endfunction

  always @(negedge cs_n) begin bitn = 0; cs_falls++; end
  always @(posedge sck) if (!cs_n) begin
    sh = {sh[6:0], mosi};
    bitn++;
    if (bitn % 8 == 0 && bitn / 8 <= 128) rxb[bitn/8 - 1] = sh;
  end
  always @(negedge sck) if (!cs_n) miso = mbit(bitn);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(A_CTRL, s);
      if (!s[2]) return;
    end
  endtask

  function automatic logic [31:0] cw(int cyc, int cnt, bit go, logic [1:0] w1c);
    return (32'(cnt) << 16) | (32'(cyc) << 4) | (32'(go) << 3) | 32'(w1c);
  endfunction

  task automatic buf_byte(input int i, output logic [7:0] b);
    logic [31:0] d;
    rd(A_BUF + 7'(i & ~3), d);
    b = d[8*(i%4) +: 8];
  endtask

  logic [31:0] v;
  logic [7:0]  b;
  int          f0;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_ADDR, v);  chk("R1 addr", v, 0);
    rd(A_PIDX, v);  chk("R1 pidx", v, 0);
    rd(A_PDATA, v); chk("R1 pdata", v, 0);
    chk("R1 pins", {30'b0, cs_n, sck}, 32'h2);

    // R3 read sweep, every count, each ending on the last byte of a page
    for (int c = 0; c < 64; c++) begin
      logic [23:0] a;
      a = 24'h0A0000 + 24'(c << 8) + 24'(255 - c);
      wr(A_ADDR, 32'(a), 4'hF);
      f0 = cs_falls;
      wr(A_CTRL, cw(0, c, 1, 2'b11), 4'hF);
      wait_idle();
      rd(A_CTRL, v); chk("R2 R7 ctrl after read", v, cw(0, c, 0, 2'b01));
      chk("R3 one select", cs_falls, f0 + 1);
      chk("R3 frame", {rxb[0], rxb[1], rxb[2], rxb[3]}, {8'h03, a});
      chk("R3 length", bitn, (5 + c) * 8);
      for (int i = 0; i <= c; i++) begin
        buf_byte(i, b);
        chk("R3 data", 32'(b), 32'(fpat(a + 24'(i))));
      end
    end

    // R8 clear done without go
    wr(A_CTRL, 32'h1, 4'hF);
    rd(A_CTRL, v); chk("R8 w1c done", v[1:0], 0);

    // R4 R12 program: byte writes, address low bits ignored
    for (int c = 0; c < 64; c += 21) begin
      for (int i = 0; i <= c; i++)
        wr(A_BUF + 7'(i), 32'(8'(i * 3 + c + 8'h11)) << (8 * (i % 4)), 4'(1 << (i % 4)));
      for (int i = 0; i <= c; i++) begin
        buf_byte(i, b);
        chk("R12 byte write", 32'(b), 32'(8'(i * 3 + c + 8'h11)));
      end
      wr(A_ADDR, 32'h123400, 4'hF);
      wr(A_CTRL, cw(1, c, 1, 2'b11), 4'hF);
      wait_idle();
      chk("R4 frame", {rxb[0], rxb[1], rxb[2], rxb[3]}, 32'h02123400);
      chk("R4 length", bitn, (5 + c) * 8);
      for (int i = 0; i <= c; i++)
        chk("R4 data", 32'(rxb[4 + i]), 32'(8'(i * 3 + c + 8'h11)));
    end

    // R5 erases
    wr(A_ADDR, 32'h345000, 4'hF);
    wr(A_CTRL, cw(2, 0, 1, 2'b11), 4'hF);
    wait_idle();
    chk("R5 4k frame", {rxb[0], rxb[1], rxb[2], rxb[3]}, 32'h20345000);
    chk("R5 4k length", bitn, 32);
    wr(A_ADDR, 32'h670000, 4'hF);
    wr(A_CTRL, cw(3, 5, 1, 2'b11), 4'hF);
    wait_idle();
    chk("R5 64k frame", {rxb[0], rxb[1], rxb[2], rxb[3]}, 32'hD8670000);
    chk("R5 64k length", bitn, 32);

    // R6 read status
    wr(A_CTRL, cw(4, 9, 1, 2'b11), 4'hF);
    wait_idle();
    chk("R6 opcode", 32'(rxb[0]), 32'h05);
    chk("R6 length", bitn, 16);
    buf_byte(0, b); chk("R6 status byte", 32'(b), 32'h9C);

    // R9 errors: misaligned erases, invalid code, page crossing
    f0 = cs_falls;
    wr(A_ADDR, 32'h345800, 4'hF);
    wr(A_CTRL, cw(2, 0, 1, 2'b11), 4'hF);
    rd(A_CTRL, v); chk("R9 misaligned 4k", v[2:0], 3'b010);
    wr(A_ADDR, 32'h671000, 4'hF);
    wr(A_CTRL, cw(3, 0, 1, 2'b11), 4'hF);
    rd(A_CTRL, v); chk("R9 misaligned 64k", v[2:0], 3'b010);
    wr(A_ADDR, 32'h000000, 4'hF);
    for (int op = 5; op < 8; op++) begin
      wr(A_CTRL, cw(op, 0, 1, 2'b11), 4'hF);
      rd(A_CTRL, v); chk("R9 invalid code", v[2:0], 3'b010);
    end
    wr(A_ADDR, 32'h0000F1, 4'hF);
    wr(A_CTRL, cw(0, 15, 1, 2'b11), 4'hF);
    rd(A_CTRL, v); chk("R9 read page cross", v[2:0], 3'b010);
    wr(A_ADDR, 32'h0001C1, 4'hF);
    wr(A_CTRL, cw(1, 63, 1, 2'b11), 4'hF);
    rd(A_CTRL, v); chk("R9 program page cross", v[2:0], 3'b010);
    repeat (4) @(negedge clk);
    chk("R9 no select", cs_falls, f0);

    // R8 write of 0 keeps error; go with w1c clears stale error
    wr(A_CTRL, 32'h1, 4'hF);
    rd(A_CTRL, v); chk("R8 err kept", v[1], 1'b1);
    wr(A_ADDR, 32'h0000F0, 4'hF);
    wr(A_CTRL, cw(0, 15, 1, 2'b11), 4'hF);
    wait_idle();
    rd(A_CTRL, v); chk("R8 stale cleared", v[1:0], 2'b01);

    // R10 go and index write while busy
    wr(A_ADDR, 32'h001100, 4'hF);
    f0 = cs_falls;
    wr(A_CTRL, cw(0, 63, 1, 2'b11), 4'hF);
    repeat (10) @(negedge clk);
    wr(A_CTRL, cw(1, 3, 1, 2'b00), 4'hF);
    wr(A_PIDX, 32'h1FFF, 4'hF);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R10 single select", cs_falls, f0 + 1);
    chk("R10 opcode", 32'(rxb[0]), 32'h03);
    chk("R10 length", bitn, 68 * 8);
    rd(A_CTRL, v); chk("R10 fields kept", v, cw(0, 63, 0, 2'b01));
    rd(A_PIDX, v); chk("R10 pidx kept", v, 0);

    // R11 parameter fetch, select 2, index byte offset 0x3DF
    wr(A_CTRL, 32'h3, 4'hF);
    wr(A_PIDX, 32'hFFFF_23DF, 4'hF);
    wait_idle();
    rd(A_PIDX, v); chk("R11 pidx readback", v, 32'h23DC);
    chk("R11 frame", {rxb[0], rxb[1], rxb[2], rxb[3]}, 32'h5A0023DC);
    chk("R11 length", bitn, 72);
    rd(A_PDATA, v);
    chk("R11 word", v, {fpat(24'h0023DF), fpat(24'h0023DE), fpat(24'h0023DD), fpat(24'h0023DC)});
    rd(A_CTRL, v); chk("R11 done", v[2:0], 3'b001);

    // R12 low address bits ignored on word registers
    rd(A_CTRL + 7'd2, v); chk("R12 alias ctrl", v[2:0], 3'b001);
    rd(A_ADDR + 7'd3, v); chk("R12 alias addr", v, 32'h001100);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule